// File: doc/BRIEF.md
# Delayed Duplicate-Token Checker with End Watchdog

This block watches a control network in which exactly one element should hold a token in each cycle. It does not compare every element against every other one. Instead it uses a small circuit that catches a second token once that token, or the original one, arrives at one of a few chosen monitor elements. It also catches two tokens that sit in a pair of elements feeding a common successor, where they would otherwise merge into one on the next cycle and disappear. Because of this, how fast an error is caught depends on the network's wiring, not on the checker's own delay.

The network is allowed to rest in the all-zero state between runs, so an empty network is not treated as an error by default. A lost token is caught by a watchdog instead. The network's start pulse arms a countdown, and the network's end pulse must arrive before the countdown runs out. Two things are parameters: the network's successor map, from which the merge pairs are worked out at elaboration, and the monitor set. The timeout length is an input. The error flag and the cause code are registered and stay set until a synchronous clear.

Top module: `token_dup_guard`

## Requirements
- R1: After reset, err_o is 0 and cause_o is 0 (none). err_o is 1 exactly when cause_o is not 0.
- R2: For every monitor element m (default 3 and 7), a state where bit m is set and any other bit is also set makes err_o 1 with cause_o = 1 (duplicate) one clock later.
- R3: Two bits i and j whose elements share a successor in the successor map (default elements 1 and 2, which both feed 3) make err_o 1 with cause 1 one clock later. Two bits that are neither a monitor nor a merge pair (for example 4 and 5) raise nothing.
- R4: A state with one bit set, or the all-zero state when the zero check parameter is 0, raises no error.
- R5: A start pulse with a timeout T arms the watchdog. If the end pulse arrives within T cycles after the start cycle, there is no error. Otherwise err_o is 1 with cause_o = 2 (missing end) starting in cycle start+T+1.
- R6: A timeout of 0 leaves the watchdog unarmed. A start pulse while the watchdog is armed reloads it with the new timeout.
- R7: Once set, err_o and cause_o stay unchanged until clr_i, whatever errors follow.
- R8: A clr_i pulse clears err_o and cause_o on the next clock. A detection in the same cycle as the clear is still recorded.
- R9: If a duplicate and a watchdog expiry happen in the same cycle, cause_o reads 1 (duplicate).
- R10: On the default 8-element network, a second token added while the first is still in flight is flagged no more than 7 cycles after it appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| state_i | input | N | Occupancy of each network element, one bit each |
| start_i | input | 1 | Network start pulse; arms the watchdog |
| end_i | input | 1 | Network end pulse; disarms the watchdog |
| cfg_timeout_i | input | TW | Cycles allowed from start to end; 0 disables the watchdog |
| clr_i | input | 1 | Synchronous clear of the error flag and cause |
| err_o | output | 1 | Sticky error flag |
| cause_o | output | 2 | First cause: 0 none, 1 duplicate, 2 missing end, 3 empty network |

## Verification
The two functions that can fire in the same cycle are the duplicate detector and the end watchdog expiring. The bench sets up this overlap on purpose. It uses a run whose timeout is one cycle shorter than the network's walk. Then, in the last cycle the countdown allows, it adds a second token at a monitor element, so both detections happen together. The result is judged by the cause code, which must read duplicate. A neighbouring directed run with no added token must read missing end, so the bench can tell the two causes apart.

// File: rtl/tdg_pkg.sv
package tdg_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_DUP   = 2'd1,
    CAUSE_MISS  = 2'd2,
    CAUSE_EMPTY = 2'd3
  } cause_e;
endpackage

// File: rtl/tdg_dup_net.sv
// Combinational duplicate detector: monitor elements compared against all
// other elements, plus AND gates on element pairs that share a successor.
module tdg_dup_net #(
  parameter int              N          = 8,
  parameter logic [N-1:0]    MON_MASK   = 8'b1000_1000,
  parameter logic [N*N-1:0]  SUCC_MAP   = 64'h0080_4020_1008_0806,
  parameter bit              ZERO_CHECK = 1'b0
) (
  input  logic [N-1:0] state_i,
  output logic         dup_o,
  output logic         empty_o
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0]   mon_hit;
  logic [N*N-1:0] pair_hit;

  // Monitor detectors: element m set together with any other element.
  for (genvar m = 0; m < N; m++) begin : g_mon
    localparam logic [N-1:0] OTHERS = ~(ONE << m);
    if (MON_MASK[m]) begin : g_on
      assign mon_hit[m] = state_i[m] & (|(state_i & OTHERS));
    end else begin : g_off
      assign mon_hit[m] = 1'b0;
    end
  end

  // Merge-pair detectors: row i of SUCC_MAP lists the successors of i.
  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      localparam logic SHARE = |(SUCC_MAP[i*N +: N] & SUCC_MAP[j*N +: N]);
      if (j > i && SHARE) begin : g_pair
        assign pair_hit[i*N+j] = state_i[i] & state_i[j];
      end else begin : g_none
        assign pair_hit[i*N+j] = 1'b0;
      end
    end
  end

  assign dup_o = (|mon_hit) | (|pair_hit);

  if (ZERO_CHECK) begin : g_zero
    assign empty_o = ~(|state_i);
  end else begin : g_nozero
    assign empty_o = 1'b0;
  end
endmodule

// File: rtl/tdg_end_watchdog.sv
// Countdown armed by the start pulse, disarmed by the end pulse.
module tdg_end_watchdog #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          end_i,
  input  logic [TW-1:0] cfg_timeout_i,
  output logic          expire_o
);
  localparam logic [TW-1:0] LAST = TW'(1);

  logic          armed_q;
  logic [TW-1:0] left_q;

  assign expire_o = armed_q & ~start_i & ~end_i & (left_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      left_q  <= '0;
    end else if (start_i) begin
      armed_q <= (cfg_timeout_i != '0);
      left_q  <= cfg_timeout_i;
    end else if (armed_q) begin
      if (end_i || left_q == LAST) begin
        armed_q <= 1'b0;
      end else begin
        left_q <= left_q - LAST;
      end
    end
  end
endmodule

// File: rtl/tdg_cause_reg.sv
// Sticky error flag and first-cause register with synchronous clear.
module tdg_cause_reg
  import tdg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr_i,
  input  logic       dup_i,
  input  logic       miss_i,
  input  logic       empty_i,
  output logic       err_o,
  output logic [1:0] cause_o
);
  cause_e pick_c;
  logic   any_w;

  always_comb begin
    if (dup_i)        pick_c = CAUSE_DUP;
    else if (miss_i)  pick_c = CAUSE_MISS;
    else if (empty_i) pick_c = CAUSE_EMPTY;
    else              pick_c = CAUSE_NONE;
  end

  assign any_w = dup_i | miss_i | empty_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_o   <= 1'b0;
      cause_o <= CAUSE_NONE;
    end else if (clr_i) begin
      err_o   <= any_w;
      cause_o <= pick_c;
    end else if (!err_o && any_w) begin
      err_o   <= 1'b1;
      cause_o <= pick_c;
    end
  end
endmodule

// File: rtl/token_dup_guard.sv
module token_dup_guard
  import tdg_pkg::*;
#(
  parameter int              N          = 8,
  parameter int              TW         = 16,
  parameter logic [N-1:0]    MON_MASK   = 8'b1000_1000,
  parameter logic [N*N-1:0]  SUCC_MAP   = 64'h0080_4020_1008_0806,
  parameter bit              ZERO_CHECK = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  state_i,
  input  logic          start_i,
  input  logic          end_i,
  input  logic [TW-1:0] cfg_timeout_i,
  input  logic          clr_i,
  output logic          err_o,
  output logic [1:0]    cause_o
);
  logic dup_w;
  logic empty_w;
  logic miss_w;

  tdg_dup_net #(
    .N(N), .MON_MASK(MON_MASK), .SUCC_MAP(SUCC_MAP), .ZERO_CHECK(ZERO_CHECK)
  ) u_net (
    .state_i (state_i),
    .dup_o   (dup_w),
    .empty_o (empty_w)
  );

  tdg_end_watchdog #(.TW(TW)) u_wdog (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .end_i         (end_i),
    .cfg_timeout_i (cfg_timeout_i),
    .expire_o      (miss_w)
  );

  tdg_cause_reg u_cause (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (clr_i),
    .dup_i   (dup_w),
    .miss_i  (miss_w),
    .empty_i (empty_w),
    .err_o   (err_o),
    .cause_o (cause_o)
  );
endmodule

// File: rtl/tdg_checker.sv
module tdg_checker #(
  parameter int           N        = 8,
  parameter logic [N-1:0] MON_MASK = 8'b1000_1000
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] state_i,
  input logic         end_i,
  input logic         clr_i,
  input logic         err_o,
  input logic [1:0]   cause_o
);
  logic mon_seen;
  assign mon_seen = (|(state_i & MON_MASK)) && ($countones(state_i) >= 2);

  assert_flag_matches_cause_R1: assert property (@(posedge clk) disable iff (rst)
    err_o == (cause_o != 2'd0));

  assert_monitor_flags_R2: assert property (@(posedge clk) disable iff (rst)
    mon_seen |=> err_o);

  assert_miss_needs_no_end_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(err_o) && cause_o == 2'd2) |-> !$past(end_i));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (err_o && !clr_i) |=> err_o);

  assert_cause_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (err_o && !clr_i) |=> $stable(cause_o));

  assert_dup_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (mon_seen && (!err_o || clr_i)) |=> cause_o == 2'd1);
endmodule

bind token_dup_guard tdg_checker #(.N(N), .MON_MASK(MON_MASK)) u_tdg_chk (
  .clk     (clk),
  .rst     (rst),
  .state_i (state_i),
  .end_i   (end_i),
  .clr_i   (clr_i),
  .err_o   (err_o),
  .cause_o (cause_o)
);

// File: tb/test_token_dup_guard.sv
`timescale 1ns/1ps
module test_token_dup_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  state_i = '0;
  logic        start_i = 1'b0;
  logic        end_i = 1'b0;
  logic [15:0] cfg_timeout_i = '0;
  logic        clr_i = 1'b0;
  logic        err_o;
  logic [1:0]  cause_o;

  int    n_chk = 0;
  int    n_bad = 0;
  int    seed = 11;
  string cur_req = "R1";

  always #4 clk = ~clk;

  token_dup_guard i_token_dup_guard (
    .clk(clk), .rst(rst), .state_i(state_i), .start_i(start_i), .end_i(end_i),
    .cfg_timeout_i(cfg_timeout_i), .clr_i(clr_i), .err_o(err_o), .cause_o(cause_o)
  );

  // Duplicate rule from R2/R3: monitors 3 and 7, merge pair (1,2).
  function automatic logic dup_expected(input logic [7:0] v);
    return ((v[3] | v[7]) && ($countones(v) >= 2)) || (v[1] && v[2]);
  endfunction

  // Bench network: 0 -> 1 or 2, 1 -> 3, 2 -> 3, then a chain up to 7, which exits.
  function automatic logic [7:0] advance(input logic [7:0] v, input logic pick);
    logic [7:0] n;
    n[0] = 1'b0;
    n[1] = v[0] & ~pick;
    n[2] = v[0] & pick;
    n[3] = v[1] | v[2];
    n[4] = v[3];
    n[5] = v[4];
    n[6] = v[5];
    n[7] = v[6];
    return n;
  endfunction

  // Expected-value model built from R1..R9.
  logic        exp_err = 1'b0;
  logic [1:0]  exp_cause = 2'd0;
  logic        m_run = 1'b0;
  logic [15:0] m_left = '0;

  always @(posedge clk) begin : ref_model
    logic       expire;
    logic [1:0] nc;
    if (rst) begin
      exp_err <= 1'b0; exp_cause <= 2'd0; m_run <= 1'b0; m_left <= '0;
    end else begin
      expire = m_run && !start_i && !end_i && (m_left == 16'd1);
      if (start_i) begin
        m_run <= (cfg_timeout_i != 0); m_left <= cfg_timeout_i;
      end else if (m_run) begin
        if (end_i || m_left == 16'd1) m_run <= 1'b0;
        else m_left <= m_left - 16'd1;
      end
      nc = dup_expected(state_i) ? 2'd1 : (expire ? 2'd2 : 2'd0);
      if (clr_i) begin
        exp_err <= (nc != 0); exp_cause <= nc;
      end else if (!exp_err && nc != 0) begin
        exp_err <= 1'b1; exp_cause <= nc;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input logic [7:0] st, input logic s, input logic e,
                      input logic c, input logic [15:0] t);
    @(negedge clk);
    check(cur_req, {err_o, cause_o}, {exp_err, exp_cause});
    state_i = st; start_i = s; end_i = e; clr_i = c; cfg_timeout_i = t;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(8'h00, 1'b0, 1'b0, 1'b0, cfg_timeout_i);
  endtask

  task automatic expect_out(input string req, input logic e, input logic [1:0] c);
    check(req, {err_o, cause_o}, {e, c});
  endtask

  // One network run: start in cycle 0, token walks from element 0.
  task automatic run_job(input logic [15:0] t, input logic clr0, input bit drop,
                         input int inj_k, input logic [7:0] inj_v,
                         output bit made_dup, output int lat);
    logic [7:0] net = '0;
    int det = -1;
    made_dup = 1'b0;
    tick(8'h00, 1'b1, 1'b0, clr0, t);
    for (int k = 1; k <= 14; k++) begin
      if (k == 1) net = drop ? 8'h00 : 8'h01;
      else        net = advance(net, $random(seed) & 1);
      if (k == inj_k) begin
        if (net != 0 && (net & inj_v) == 0) made_dup = 1'b1;
        net = net | inj_v;
      end
      tick(net, 1'b0, net[7], 1'b0, t);
      if (err_o && det < 0) det = k - 1;
    end
    lat = (det >= 0) ? det - inj_k : -1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    bit made;
    int lat;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1";
    expect_out("R1", 1'b0, 2'd0);
    idle(2);

    // R4: single token anywhere, and empty network
    cur_req = "R4";
    for (int i = 0; i < 8; i++) tick(8'h01 << i, 1'b0, 1'b0, 1'b0, 16'd0);
    idle(4);
    expect_out("R4", 1'b0, 2'd0);

    // R5: walk needs 7 cycles; T=7 passes
    cur_req = "R5";
    run_job(16'd7, 1'b0, 1'b0, 0, 8'h00, made, lat);
    expect_out("R5 end in time", 1'b0, 2'd0);
    // R5: T=6 expires
    run_job(16'd6, 1'b0, 1'b0, 0, 8'h00, made, lat);
    expect_out("R5 missing end", 1'b1, 2'd2);

    // R8: clear
    cur_req = "R8";
    tick(8'h00, 1'b0, 1'b0, 1'b1, 16'd0);
    idle(1);
    expect_out("R8 clear", 1'b0, 2'd0);

    // R6: T=0 disarms; restart reloads
    cur_req = "R6";
    tick(8'h00, 1'b1, 1'b0, 1'b0, 16'd0);
    idle(30);
    expect_out("R6 zero timeout", 1'b0, 2'd0);
    tick(8'h00, 1'b1, 1'b0, 1'b0, 16'd3);
    idle(1);
    tick(8'h00, 1'b1, 1'b0, 1'b0, 16'd20);
    idle(10);
    expect_out("R6 restart", 1'b0, 2'd0);
    tick(8'h00, 1'b0, 1'b1, 1'b0, 16'd20);
    idle(15);
    expect_out("R6 stopped", 1'b0, 2'd0);

    // R3: merge pair and a non-pair
    cur_req = "R3";
    tick(8'h30, 1'b0, 1'b0, 1'b0, 16'd0);
    idle(1);
    expect_out("R3 non-pair 4,5", 1'b0, 2'd0);
    tick(8'h06, 1'b0, 1'b0, 1'b0, 16'd0);
    idle(1);
    expect_out("R3 pair 1,2", 1'b1, 2'd1);

    // R7: later missing end does not change cause
    cur_req = "R7";
    run_job(16'd2, 1'b0, 1'b0, 0, 8'h00, made, lat);
    expect_out("R7 sticky", 1'b1, 2'd1);

    // R8: detection in the clear cycle is kept
    cur_req = "R8";
    tick(8'h06, 1'b0, 1'b0, 1'b1, 16'd0);
    idle(1);
    expect_out("R8 clear with hit", 1'b1, 2'd1);

    // R2: each monitor
    cur_req = "R2";
    tick(8'h00, 1'b0, 1'b0, 1'b1, 16'd0);
    tick(8'h28, 1'b0, 1'b0, 1'b0, 16'd0);
    idle(1);
    expect_out("R2 monitor 3", 1'b1, 2'd1);
    tick(8'h00, 1'b0, 1'b0, 1'b1, 16'd0);
    tick(8'h81, 1'b0, 1'b0, 1'b0, 16'd0);
    idle(1);
    expect_out("R2 monitor 7", 1'b1, 2'd1);
    tick(8'h00, 1'b0, 1'b0, 1'b1, 16'd0);
    idle(1);

    // R9: duplicate at monitor 3 in the cycle the T=6 countdown expires
    cur_req = "R9";
    run_job(16'd6, 1'b1, 1'b0, 6, 8'h08, made, lat);
    expect_out("R9 priority", 1'b1, 2'd1);

    // R10: random second tokens
    cur_req = "R10";
    for (int it = 0; it < 40; it++) begin
      int k;
      logic [7:0] v;
      k = 1 + ($unsigned($random(seed)) % 6);
      v = 8'h01 << ($unsigned($random(seed)) % 8);
      run_job(16'd20, 1'b1, 1'b0, k, v, made, lat);
      if (made) begin
        n_chk++;
        if (lat < 0 || lat > 7) begin
          n_bad++;
          $display("FAIL R10: actual latency=%0d expected<=7", lat);
        end
      end
    end
    tick(8'h00, 1'b0, 1'b0, 1'b1, 16'd0);
    idle(3);
    expect_out("R10 final clear", 1'b0, 2'd0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule